// File: doc/BRIEF.md
# DMA Channel Destination Address and Transfer Count Unit

This block holds the destination address and the transfer count of one DMA channel and updates both as transfers complete. Software loads the two registers through a small register port while the channel is idle and then starts the channel. Each time the transfer engine signals a completed transfer, the address moves by the transfer size in the selected direction and the count drops by one. When a nonzero count runs out, the block raises a one-cycle end pulse and the channel stops. A zero count turns the counter off, so the channel runs without limit and never raises the end pulse.

Both registers are 32 bits wide at the port, but only the low 24 bits exist. In single-address mode with an acknowledge-served destination, the address register is neither used nor advanced, and the address-valid output stays low.

Top module: `dma_dst_chan`

## Requirements
- R1: Bits 31 to 24 of every register read are zero, and the write data in those bits is discarded.
- R2: `cpu_rdata` shows the address register when `cpu_sel`=0 and the count register when `cpu_sel`=1. It is a combinational function of registered state, so all 32 bits come from the same cycle.
- R3: A write while the channel is idle takes effect at the next clock edge. A write while `chan_active`=1 is ignored.
- R4: A `go` pulse while idle sets `chan_active` at the next edge.
- R5: When `chan_active`=1, `xfer_done`=1 and `dack_mode`=0, the address moves at the next edge by a step of 1, 2, 4 or 4 for `xfer_size` codes 0, 1, 2 or 3. It increments for `addr_dir`=1, decrements for `addr_dir`=2 and holds for `addr_dir` 0 or 3. It wraps modulo 2^24.
- R6: With `dack_mode`=1, a completed transfer leaves the address unchanged, and `dst_addr_vld` (defined as `chan_active` and not `dack_mode`) is low.
- R7: Each completed transfer while active decrements a nonzero count by one. A count of 0xFFFFFF becomes 0xFFFFFE.
- R8: When the count steps from 1 to 0, `xfer_end_irq` is high for exactly one cycle, and `chan_active` drops at that same edge.
- R9: A count of zero stays at zero under transfers, raises no end pulse and leaves the channel active.
- R10: `xfer_done` while idle changes neither register.
- R11: After reset the count is 0, `chan_active` is 0 and `xfer_end_irq` is 0. The address stays undefined until software writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_sel | input | 1 | 0 selects address, 1 selects count |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data |
| go | input | 1 | Start the channel |
| xfer_done | input | 1 | One-cycle completed-transfer strobe |
| xfer_size | input | 2 | 0 byte, 1 word, 2 and 3 longword |
| addr_dir | input | 2 | 0 fixed, 1 increment, 2 decrement, 3 fixed |
| dack_mode | input | 1 | Destination is an acknowledge-served device |
| dst_addr | output | 24 | Current destination address |
| dst_addr_vld | output | 1 | Address is driven for the transfer |
| remain_cnt | output | 24 | Remaining transfer count |
| chan_active | output | 1 | Channel running |
| xfer_end_irq | output | 1 | Transfer-end pulse |

## Verification
The bench sweeps every size code against every direction code from start addresses that sit next to both 24-bit boundaries. A design with a wrong step table or without wraparound would show a wrong address after the first transfer. Counts from one upward check where the end pulse falls: an off-by-one counter would fire a transfer early or late, or would leave the channel active. A zero count is run with many transfers, so a design that decrements through zero or fires on zero would wrap to 0xFFFFFF or raise a pulse. Writes with the upper byte set, writes while active, and strobes while idle catch designs that let software or stray strobes alter state they should not.

// File: rtl/dma_dst_pkg.sv
package dma_dst_pkg;
  typedef enum logic [1:0] {
    DIR_FIXED = 2'd0,
    DIR_INC   = 2'd1,
    DIR_DEC   = 2'd2,
    DIR_HOLD  = 2'd3
  } addr_dir_e;

  // step in bytes for a size code: byte, word, longword, longword
  function automatic logic [2:0] step_of(input logic [1:0] size);
    case (size)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_dst_addr.sv
module dma_dst_addr
  import dma_dst_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_val,
  input  logic          upd_en,
  input  logic [1:0]    size,
  input  logic [1:0]    dir,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d, step_w;
  logic          en;

  assign step_w = AW'(step_of(size));

  always_comb begin
    addr_d = addr_q;
    if (ld_en) begin
      addr_d = ld_val;
    end else if (upd_en) begin
      case (addr_dir_e'(dir))
        DIR_INC: addr_d = addr_q + step_w;
        DIR_DEC: addr_d = addr_q - step_w;
        default: addr_d = addr_q;
      endcase
    end
  end

  assign en = ld_en | upd_en;

  // address holds no reset value: software must load it before use
  always_ff @(posedge clk) begin
    if (en) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_val,
  input  logic          go,
  input  logic          done,
  output logic [CW-1:0] count,
  output logic          active,
  output logic          end_pulse
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, end_q, end_d;
  logic          dec_hit, last_hit, cnt_en;

  assign dec_hit  = act_q && done && (cnt_q != '0);
  assign last_hit = dec_hit && (cnt_q == CW'(1));
  assign cnt_en   = ld_en | dec_hit;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_en)        cnt_d = ld_val;
    else if (dec_hit) cnt_d = cnt_q - CW'(1);
  end

  always_comb begin
    act_d = act_q;
    if (!act_q && go) act_d = 1'b1;
    else if (last_hit) act_d = 1'b0;
    end_d = last_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      act_q <= act_d;
      end_q <= end_d;
    end
  end

  assign count     = cnt_q;
  assign active    = act_q;
  assign end_pulse = end_q;
endmodule

// File: rtl/dma_dst_chan.sv
module dma_dst_chan #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr_en,
  input  logic          cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          go,
  input  logic          xfer_done,
  input  logic [1:0]    xfer_size,
  input  logic [1:0]    addr_dir,
  input  logic          dack_mode,
  output logic [AW-1:0] dst_addr,
  output logic          dst_addr_vld,
  output logic [AW-1:0] remain_cnt,
  output logic          chan_active,
  output logic          xfer_end_irq
);
  localparam int PAD = DW - AW;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       wr_addr, wr_cnt, addr_upd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_addr  = cpu_wr_en && !cpu_sel && !chan_active;
  assign wr_cnt   = cpu_wr_en &&  cpu_sel && !chan_active;
  assign addr_upd = chan_active && xfer_done && !dack_mode;

  dma_dst_addr #(.AW(AW)) u_addr (
    .clk    (clk),
    .ld_en  (wr_addr),
    .ld_val (cpu_wdata[AW-1:0]),
    .upd_en (addr_upd),
    .size   (xfer_size),
    .dir    (addr_dir),
    .addr   (dst_addr)
  );

  dma_xfer_cnt #(.CW(AW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ld_en     (wr_cnt),
    .ld_val    (cpu_wdata[AW-1:0]),
    .go        (go),
    .done      (xfer_done),
    .count     (remain_cnt),
    .active    (chan_active),
    .end_pulse (xfer_end_irq)
  );

  assign dst_addr_vld = chan_active && !dack_mode;
  assign cpu_rdata    = cpu_sel ? {{PAD{1'b0}}, remain_cnt}
                                : {{PAD{1'b0}}, dst_addr};
endmodule

// File: rtl/dma_dst_chan_chk.sv
module dma_dst_chan_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr_en,
  input logic [DW-1:0] cpu_rdata,
  input logic          xfer_done,
  input logic [1:0]    xfer_size,
  input logic [1:0]    addr_dir,
  input logic          dack_mode,
  input logic [AW-1:0] dst_addr,
  input logic          dst_addr_vld,
  input logic [AW-1:0] remain_cnt,
  input logic          chan_active,
  input logic          xfer_end_irq
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[DW-1:AW] == '0);

  p_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && cpu_wr_en && !xfer_done |=> $stable(remain_cnt));

  p_inc_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && xfer_done && !dack_mode && addr_dir == 2'd1 && xfer_size == 2'd0
    |=> dst_addr == AW'($past(dst_addr) + AW'(1)));

  p_fixed_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && (addr_dir == 2'd0 || addr_dir == 2'd3) |=> $stable(dst_addr));

  p_dack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && dack_mode |=> $stable(dst_addr));

  p_dack_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dack_mode |-> !dst_addr_vld);

  p_count_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && xfer_done && remain_cnt != '0
    |=> remain_cnt == AW'($past(remain_cnt) - AW'(1)));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end_irq |=> !xfer_end_irq);

  p_irq_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end_irq |-> !chan_active && remain_cnt == '0);

  p_zero_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && remain_cnt == '0 |=> !xfer_end_irq && chan_active);
endmodule

bind dma_dst_chan dma_dst_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_wr_en    (cpu_wr_en),
  .cpu_rdata    (cpu_rdata),
  .xfer_done    (xfer_done),
  .xfer_size    (xfer_size),
  .addr_dir     (addr_dir),
  .dack_mode    (dack_mode),
  .dst_addr     (dst_addr),
  .dst_addr_vld (dst_addr_vld),
  .remain_cnt   (remain_cnt),
  .chan_active  (chan_active),
  .xfer_end_irq (xfer_end_irq)
);

// File: tb/dma_dst_chan_test.sv
module dma_dst_chan_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en, cpu_sel, go, xfer_done, dack_mode;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic [1:0]  xfer_size, addr_dir;
  logic [23:0] dst_addr, remain_cnt;
  logic        dst_addr_vld, chan_active, xfer_end_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_dst_chan uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .go(go),
    .xfer_done(xfer_done), .xfer_size(xfer_size), .addr_dir(addr_dir),
    .dack_mode(dack_mode), .dst_addr(dst_addr), .dst_addr_vld(dst_addr_vld),
    .remain_cnt(remain_cnt), .chan_active(chan_active),
    .xfer_end_irq(xfer_end_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cpu_wr_en = 0; cpu_sel = 0; cpu_wdata = '0; go = 0;
    xfer_done = 0; xfer_size = 0; addr_dir = 0; dack_mode = 0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    cpu_sel = sel; cpu_wdata = d; cpu_wr_en = 1'b1;
    step();
    cpu_wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    cpu_sel = sel;
    #1;
    d = cpu_rdata;
  endtask

  task automatic start();
    go = 1'b1;
    step();
    go = 1'b0;
  endtask

  task automatic xfer();
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
  endtask

  function automatic logic [23:0] nxt(input logic [23:0] a, input int sz, input int dr);
    int s;
    s = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (dr == 1) return a + 24'(s);
    if (dr == 2) return a - 24'(s);
    return a;
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [23:0] ea;
    logic [23:0] starts [3];
    starts[0] = 24'h000002; starts[1] = 24'hFFFFFE; starts[2] = 24'h123457;

    do_reset();
    // R11 reset state
    chk("R11 cnt", {8'h0, remain_cnt}, 32'h0);
    chk("R11 active", {31'h0, chan_active}, 32'h0);
    chk("R11 irq", {31'h0, xfer_end_irq}, 32'h0);

    // R1, R2, R3 idle writes with upper byte set
    wr(1'b0, 32'hAB123456);
    rd(1'b0, r); chk("R1 R2 addr read", r, 32'h00123456);
    wr(1'b1, 32'hCD000007);
    rd(1'b1, r); chk("R1 R2 cnt read", r, 32'h00000007);
    chk("R3 idle write", {8'h0, remain_cnt}, 32'h7);

    // R10 strobe while idle
    xfer_size = 2; addr_dir = 1;
    xfer();
    chk("R10 addr", {8'h0, dst_addr}, 32'h123456);
    chk("R10 cnt", {8'h0, remain_cnt}, 32'h7);

    // R4, R5, R8 sweep over size, direction, start and count
    for (int sz = 0; sz < 4; sz++) begin
      for (int dr = 0; dr < 4; dr++) begin
        for (int si = 0; si < 3; si++) begin
          int n;
          n = 1 + ((sz + dr + si) % 3);
          xfer_size = 2'(sz); addr_dir = 2'(dr); dack_mode = 0;
          wr(1'b0, {8'h0, starts[si]});
          wr(1'b1, 32'(n));
          start();
          chk("R4 active", {31'h0, chan_active}, 32'h1);
          chk("R6 vld", {31'h0, dst_addr_vld}, 32'h1);
          ea = starts[si];
          for (int k = 0; k < n; k++) begin
            xfer();
            ea = nxt(ea, sz, dr);
            chk("R5 addr", {8'h0, dst_addr}, {8'h0, ea});
            chk("R7 cnt", {8'h0, remain_cnt}, 32'(n - k - 1));
            chk("R8 irq", {31'h0, xfer_end_irq}, (k == n - 1) ? 32'h1 : 32'h0);
            chk("R8 active", {31'h0, chan_active}, (k == n - 1) ? 32'h0 : 32'h1);
          end
          step();
          chk("R8 irq one cycle", {31'h0, xfer_end_irq}, 32'h0);
        end
      end
    end

    // R6 acknowledge-served destination
    xfer_size = 0; addr_dir = 1;
    wr(1'b0, 32'h000100);
    wr(1'b1, 32'h2);
    start();
    dack_mode = 1;
    #1;
    chk("R6 vld low", {31'h0, dst_addr_vld}, 32'h0);
    xfer();
    chk("R6 addr held", {8'h0, dst_addr}, 32'h100);
    chk("R6 cnt still counts", {8'h0, remain_cnt}, 32'h1);
    xfer();
    dack_mode = 0;
    chk("R6 addr held end", {8'h0, dst_addr}, 32'h100);

    // R9 zero count, plus R3 writes while active
    wr(1'b0, 32'h000010);
    wr(1'b1, 32'h0);
    xfer_size = 1; addr_dir = 1;
    start();
    for (int k = 0; k < 20; k++) begin
      xfer();
      chk("R9 cnt zero", {8'h0, remain_cnt}, 32'h0);
      chk("R9 no irq", {31'h0, xfer_end_irq}, 32'h0);
      chk("R9 active", {31'h0, chan_active}, 32'h1);
    end
    chk("R9 addr advanced", {8'h0, dst_addr}, 32'h10 + 32'd40);
    wr(1'b1, 32'h5);
    rd(1'b1, r); chk("R3 cnt write ignored", r, 32'h0);
    wr(1'b0, 32'h777777);
    rd(1'b0, r); chk("R3 addr write ignored", r, 32'h38);

    // R7 maximum count
    do_reset();
    wr(1'b1, 32'hFFFFFFFF);
    rd(1'b1, r); chk("R1 max cnt", r, 32'h00FFFFFF);
    wr(1'b0, 32'h0);
    start();
    xfer();
    chk("R7 max dec", {8'h0, remain_cnt}, 32'hFFFFFE);
    chk("R7 no irq", {31'h0, xfer_end_irq}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule